// File: doc/BRIEF.md
# Infrared Receive Buffer and Interrupt Controller

This block sits behind an infrared run-length encoder. The encoder delivers one byte for each pulse or space it measures, and the block stores these bytes in a receive queue. Software takes bytes out of the queue one at a time by reading a data register. A small register file programs the receiver: enables, operating mode, input polarity, noise and idle thresholds for the encoder, interrupt enables and a queue trigger level. A status word holds three sticky event flags and the number of bytes waiting. A single level interrupt output is raised for any flagged event whose enable bit is set.

Bytes arrive on a valid/ready stream. `in_ready` is high exactly when the receiver is active, meaning both global enable and receive enable are set. While ready is high the block never stalls the encoder. A byte offered when the queue is full is discarded, and this is reported as an overflow event. While ready is low, offered bytes are not taken. The encoder may hold `in_valid` for as long as it likes without causing any effect. The register port is a simple single-cycle port. Writes take effect at the clock edge. Read data is combinational from the address while `reg_rd` is high, and a read of the data register removes the byte at that edge.

The queue depth is a parameter. It must be a power of two, and the expected values are 16 or 64.

Top module: `ir_rx_ctrl`

## Requirements
- R1: After reset every register reads zero, the byte count is zero, `irq` is low and `in_ready` is low.
- R2: The control word (offset 0x00: bit0 global enable, bit1 receive enable, bits 5:4 mode), the receive config word (offset 0x10: bit2 polarity invert) and the sample word (offset 0x34: bits 7:2 noise threshold, bits 15:8 idle threshold) read back as written and drive `cfg_mode`, `cfg_pol_inv`, `cfg_noise_thr` and `cfg_idle_thr`.
- R3: `in_ready` and `rx_active` are high only when global and receive enable are both set. Reads of offset 0x20 return the accepted bytes in arrival order in bits 7:0. Each such read removes one byte. A read of an empty queue returns zero and leaves the count at zero.
- R4: The status word (offset 0x30) reports the number of stored bytes from bit 8 upward, in a field of log2(depth)+1 bits. The count never exceeds the depth.
- R5: Status bit 4, data available, becomes set the cycle after the count exceeds the trigger level held in bits from 8 upward of the enable word (offset 0x2C).
- R6: A byte accepted while the queue is full is dropped, status bit 0 (overflow) sets, and the stored bytes are unchanged.
- R7: A `pkt_end` pulse while the receiver is active sets status bit 1 (packet end). The pulse is ignored while the receiver is inactive.
- R8: Writing ones to the status word clears exactly those flags. Writing 0xFF clears all of them. A flag whose cause is still present is set again on the next cycle.
- R9: `irq` is high exactly when some status flag and its matching enable bit in the enable word (bits 0, 1 and 4) are both set.
- R10: While global enable is clear, the queue is emptied, the count reads zero, and bytes are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Encoder byte valid |
| in_ready | output | 1 | Byte accepted this cycle when valid is also high |
| in_data | input | 8 | Encoder byte (bit 7 level, bits 6:0 length) |
| pkt_end | input | 1 | Encoder idle-detect pulse marking the end of a packet |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request, level |
| rx_active | output | 1 | Receiver running, to the encoder |
| cfg_mode | output | 2 | Operating mode field |
| cfg_pol_inv | output | 1 | Invert the received signal |
| cfg_noise_thr | output | 6 | Noise threshold for the encoder |
| cfg_idle_thr | output | 8 | Idle threshold for the encoder |

## Verification
The queue is tested with a short burst that is read back in full and then read once more while empty. This separates correct ordering and count tracking from the handling of empty reads. A second test fills the queue past its depth, which distinguishes a dropped byte from an overwritten one, because the last stored byte must still be the sixteenth. The trigger level is tested one byte below the threshold and one byte above it, and a clear is issued with the cause still present, which separates a sticky flag that is set again from one that stays clear. Packet-end pulses are sent with the receiver inactive and with the interrupt enable masked, and partial clears are then applied. This checks that event sources, enables and clearing act independently.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RXCFG = 8'h10;
  localparam logic [7:0] OFS_DATA  = 8'h20;
  localparam logic [7:0] OFS_IEN   = 8'h2C;
  localparam logic [7:0] OFS_STAT  = 8'h30;
  localparam logic [7:0] OFS_SAMP  = 8'h34;

  localparam int BIT_OVF   = 0;
  localparam int BIT_PEND  = 1;
  localparam int BIT_AVAIL = 4;
  localparam int FIELD_LSB = 8;

  localparam int NUM_EV = 3;
  // event vector order: [0] overflow, [1] packet end, [2] data available
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          dropped
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, do_pop, do_push;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop & ~empty & ~flush;
  assign do_push = push & (~full | do_pop) & ~flush;
  assign dropped = push & full & ~do_pop & ~flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ir_rx_events.sv
module ir_rx_events
  import ir_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t set_ev,
  input  ev_vec_t clr_ev,
  input  ev_vec_t en_ev,
  output ev_vec_t flags,
  output logic    irq
);
  ev_vec_t hit;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_ev[i])  flags[i] <= 1'b1;
      else if (clr_ev[i])  flags[i] <= 1'b0;
    end
    assign hit[i] = flags[i] & en_ev[i];
  end

  assign irq = |hit;
endmodule

// File: rtl/ir_rx_ctrl.sv
module ir_rx_ctrl
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        pkt_end,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        rx_active,
  output logic [1:0]  cfg_mode,
  output logic        cfg_pol_inv,
  output logic [5:0]  cfg_noise_thr,
  output logic [7:0]  cfg_idle_thr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          gen_q, rxen_q, pol_q;
  logic [1:0]    mode_q;
  logic [5:0]    nthr_q;
  logic [7:0]    ithr_q;
  ev_vec_t       ien_q;
  logic [AW-1:0] trig_q;

  logic          push, pop, flush, f_empty, f_drop;
  logic [7:0]    f_head;
  logic [CW-1:0] f_count;
  ev_vec_t       set_ev, clr_ev, flags;

  logic wr_ctrl, wr_rxcfg, wr_ien, wr_stat, wr_samp;
  assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_rxcfg = reg_wr && (reg_addr == OFS_RXCFG);
  assign wr_ien   = reg_wr && (reg_addr == OFS_IEN);
  assign wr_stat  = reg_wr && (reg_addr == OFS_STAT);
  assign wr_samp  = reg_wr && (reg_addr == OFS_SAMP);

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31:16], reg_wdata[3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      rxen_q <= 1'b0;
      mode_q <= '0;
      pol_q  <= 1'b0;
      nthr_q <= '0;
      ithr_q <= '0;
      ien_q  <= '0;
      trig_q <= '0;
    end else begin
      if (wr_ctrl) begin
        gen_q  <= reg_wdata[0];
        rxen_q <= reg_wdata[1];
        mode_q <= reg_wdata[5:4];
      end
      if (wr_rxcfg) pol_q <= reg_wdata[2];
      if (wr_samp) begin
        nthr_q <= reg_wdata[7:2];
        ithr_q <= reg_wdata[15:8];
      end
      if (wr_ien) begin
        ien_q  <= {reg_wdata[BIT_AVAIL], reg_wdata[BIT_PEND], reg_wdata[BIT_OVF]};
        trig_q <= reg_wdata[FIELD_LSB +: AW];
      end
    end
  end

  assign rx_active     = gen_q & rxen_q;
  assign in_ready      = rx_active;
  assign cfg_mode      = mode_q;
  assign cfg_pol_inv   = pol_q;
  assign cfg_noise_thr = nthr_q;
  assign cfg_idle_thr  = ithr_q;

  assign push  = in_valid & in_ready;
  assign pop   = reg_rd && (reg_addr == OFS_DATA);
  assign flush = ~gen_q;

  ir_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push    (push),
    .wdata   (in_data),
    .pop     (pop),
    .head    (f_head),
    .count   (f_count),
    .empty   (f_empty),
    .dropped (f_drop)
  );

  assign set_ev[0] = f_drop;
  assign set_ev[1] = pkt_end & rx_active;
  assign set_ev[2] = (f_count > {1'b0, trig_q});
  assign clr_ev    = wr_stat ? {reg_wdata[BIT_AVAIL], reg_wdata[BIT_PEND], reg_wdata[BIT_OVF]}
                             : '0;

  ir_rx_events u_events (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (set_ev),
    .clr_ev (clr_ev),
    .en_ev  (ien_q),
    .flags  (flags),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL: begin
          reg_rdata[0]   = gen_q;
          reg_rdata[1]   = rxen_q;
          reg_rdata[5:4] = mode_q;
        end
        OFS_RXCFG: reg_rdata[2] = pol_q;
        OFS_DATA:  reg_rdata[7:0] = f_empty ? 8'h00 : f_head;
        OFS_IEN: begin
          reg_rdata[BIT_OVF]           = ien_q[0];
          reg_rdata[BIT_PEND]          = ien_q[1];
          reg_rdata[BIT_AVAIL]         = ien_q[2];
          reg_rdata[FIELD_LSB +: AW]   = trig_q;
        end
        OFS_STAT: begin
          reg_rdata[BIT_OVF]           = flags[0];
          reg_rdata[BIT_PEND]          = flags[1];
          reg_rdata[BIT_AVAIL]         = flags[2];
          reg_rdata[FIELD_LSB +: CW]   = f_count;
        end
        OFS_SAMP: begin
          reg_rdata[7:2]  = nthr_q;
          reg_rdata[15:8] = ithr_q;
        end
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ir_rx_chk.sv
module ir_rx_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gen,
  input logic          in_valid,
  input logic          in_ready,
  input logic          pkt_end,
  input logic          rx_active,
  input logic          pop,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] trig,
  input logic [2:0]    ien,
  input logic [2:0]    flags,
  input logic          irq
);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> cnt == '0);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cnt == CW'(DEPTH) && !pop) |=> (flags[0] && cnt == CW'(DEPTH)));

  p_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > {1'b0, trig}) |=> flags[2]);

  p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && pop && cnt != '0 && !(in_valid && in_ready)) |=> cnt == CW'($past(cnt) - 1'b1));

  p_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && rx_active) |=> flags[1]);

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 3'b000) |-> !irq);
endmodule

bind ir_rx_ctrl ir_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gen       (gen_q),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .pkt_end   (pkt_end),
  .rx_active (rx_active),
  .pop       (pop),
  .cnt       (f_count),
  .trig      (trig_q),
  .ien       (ien_q),
  .flags     (flags),
  .irq       (irq)
);

// File: tb/ir_rx_ctrl_tb.sv
module ir_rx_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        pkt_end = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, rx_active, cfg_pol_inv;
  logic [1:0]  cfg_mode;
  logic [5:0]  cfg_noise_thr;
  logic [7:0]  cfg_idle_thr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ir_rx_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pkt_end(pkt_end), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rx_active(rx_active), .cfg_mode(cfg_mode),
    .cfg_pol_inv(cfg_pol_inv), .cfg_noise_thr(cfg_noise_thr),
    .cfg_idle_thr(cfg_idle_thr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push_byte(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] cnt_of(logic [31:0] s);
    return (s >> 8) & 32'h1F;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    reg_read(8'h00, v); check("R1 ctrl", v, 0);
    reg_read(8'h2C, v); check("R1 ien", v, 0);
    reg_read(8'h30, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);
    check("R1 in_ready", in_ready, 0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    reg_write(8'h00, 32'h31);
    idle(1);
    check("R3 ready needs rx enable", in_ready, 0);
    reg_write(8'h00, 32'h33);
    reg_read(8'h00, v); check("R2 ctrl readback", v, 32'h33);
    check("R2 mode out", cfg_mode, 2'b11);
    check("R3 rx_active", rx_active, 1);
    reg_write(8'h10, 32'h4);
    reg_read(8'h10, v); check("R2 polarity readback", v, 32'h4);
    check("R2 polarity out", cfg_pol_inv, 1);
    reg_write(8'h34, (32'd20 << 8) | (32'd1 << 2));
    reg_read(8'h34, v); check("R2 sample readback", v, 32'h1404);
    check("R2 noise out", cfg_noise_thr, 6'd1);
    check("R2 idle out", cfg_idle_thr, 8'd20);
    reg_write(8'h00, 32'h0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    reg_write(8'h00, 32'h03);
    reg_write(8'h2C, 32'h0F00);
    for (int i = 0; i < 5; i++) push_byte(8'hA0 + 8'(i * 3));
    idle(2);
    reg_read(8'h30, v); check("R4 count after 5", cnt_of(v), 5);
    for (int i = 0; i < 5; i++) begin
      reg_read(8'h20, v); check("R3 order", v, 32'hA0 + i * 3);
    end
    idle(1);
    reg_read(8'h30, v); check("R3 count drained", cnt_of(v), 0);
    reg_read(8'h20, v); check("R3 empty read", v, 0);
    reg_read(8'h30, v); check("R3 count after empty read", cnt_of(v), 0);
    reg_write(8'h00, 32'h0);
    reg_write(8'h30, 32'hFF);
  endtask

  task automatic t_avail();
    logic [31:0] v;
    reg_write(8'h00, 32'h03);
    reg_write(8'h2C, (32'd7 << 8) | 32'h10);
    for (int i = 0; i < 7; i++) push_byte(8'(i));
    idle(2);
    reg_read(8'h30, v); check("R5 at trigger level", v & 32'h10, 0);
    check("R9 irq below level", irq, 0);
    push_byte(8'h07);
    idle(2);
    reg_read(8'h30, v); check("R5 above trigger level", v & 32'h10, 32'h10);
    check("R4 count 8", cnt_of(v), 8);
    check("R9 irq on avail", irq, 1);
    reg_write(8'h30, 32'h10);
    idle(1);
    reg_read(8'h30, v); check("R8 cause still present", v & 32'h10, 32'h10);
    reg_read(8'h20, v); check("R3 first byte", v, 0);
    reg_write(8'h30, 32'h10);
    idle(2);
    reg_read(8'h30, v); check("R8 cleared", v & 32'h10, 0);
    check("R9 irq dropped", irq, 0);
    reg_write(8'h00, 32'h0);
    reg_write(8'h30, 32'hFF);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    reg_write(8'h2C, 32'h0F01);
    reg_write(8'h00, 32'h03);
    for (int i = 0; i < DEPTH; i++) push_byte(8'h40 + 8'(i));
    idle(2);
    reg_read(8'h30, v); check("R6 no overflow yet", v & 32'h1, 0);
    push_byte(8'h99);
    idle(2);
    reg_read(8'h30, v);
    check("R6 overflow flag", v & 32'h1, 1);
    check("R4 count capped", cnt_of(v), DEPTH);
    check("R9 irq on overflow", irq, 1);
    for (int i = 0; i < DEPTH; i++) begin
      reg_read(8'h20, v);
      if (i == 0)         check("R6 first kept", v, 32'h40);
      if (i == DEPTH - 1) check("R6 last not replaced", v, 32'h40 + DEPTH - 1);
    end
    reg_read(8'h20, v); check("R6 dropped byte absent", v, 0);
    reg_write(8'h00, 32'h0);
    reg_write(8'h30, 32'hFF);
  endtask

  task automatic t_events();
    logic [31:0] v;
    reg_write(8'h2C, 32'h0F00);
    @(negedge clk); pkt_end = 1'b1; @(negedge clk); pkt_end = 1'b0;
    idle(1);
    reg_read(8'h30, v); check("R7 ignored when inactive", v & 32'h2, 0);
    reg_write(8'h00, 32'h03);
    @(negedge clk); pkt_end = 1'b1; @(negedge clk); pkt_end = 1'b0;
    idle(1);
    reg_read(8'h30, v); check("R7 packet end", v & 32'h2, 32'h2);
    check("R9 masked irq", irq, 0);
    reg_write(8'h2C, 32'h0F02);
    idle(1);
    check("R9 enabled irq", irq, 1);
    reg_write(8'h30, 32'h01);
    reg_read(8'h30, v); check("R8 partial clear", v & 32'h2, 32'h2);
    reg_write(8'h30, 32'hFF);
    reg_read(8'h30, v); check("R8 clear all", v & 32'h13, 0);
    check("R9 irq after clear", irq, 0);
    reg_write(8'h00, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    reg_write(8'h2C, 32'h0F00);
    reg_write(8'h00, 32'h03);
    for (int i = 0; i < 3; i++) push_byte(8'h55);
    idle(1);
    reg_read(8'h30, v); check("R4 count 3", cnt_of(v), 3);
    reg_write(8'h00, 32'h02);
    idle(2);
    check("R10 not ready", in_ready, 0);
    reg_read(8'h30, v); check("R10 flushed", cnt_of(v), 0);
    push_byte(8'h66);
    idle(1);
    reg_read(8'h30, v); check("R10 push ignored", cnt_of(v), 0);
    reg_write(8'h00, 32'h03);
    idle(1);
    reg_read(8'h30, v); check("R10 empty on re-enable", cnt_of(v), 0);
    reg_read(8'h20, v); check("R10 no stale byte", v, 0);
    reg_write(8'h00, 32'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_config();
    t_order();
    t_avail();
    t_overflow();
    t_events();
    t_flush();
    idle(2);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule